// File: doc/BRIEF.md
# Sleep and Power Reduction Controller

This block sits beside a small microcontroller core. It holds two byte-wide control registers on a simple register bus. The mode register selects a low-power mode and arms sleep entry. The shutdown register turns off individual peripherals. When the core reports that it executed a sleep instruction while sleep is armed, the block enters the selected mode. It then drops the clock enables of the CPU, I/O, ADC and timer domains to suit that mode. A wake pulse brings every domain back.

The two shutdown bits gate the ADC and timer clocks independently of sleep. A gated timer keeps its state and resumes when the bit is cleared. ADC shutdown also raises a flag that keeps the analog comparator off the ADC input multiplexer. The ADC must be disabled before it is shut down. If software requests ADC shutdown while the ADC is still enabled, the request is refused and an error flag is raised.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: After reset both registers read 0x00, the block is awake, every clock enable and `osc_run` are 1, and `mode_err`, `adc_pr_err` and `adc_mux_block` are 0.
- R2: The mode register is at bus address 0. Bits 3:1 hold the mode and bit 0 arms sleep. Bits 7:4 always read 0. The mode encodings are 000 idle, 001 ADC noise reduction, 010 power-down and 100 standby; every other value is reserved.
- R3: The shutdown register is at bus address 1. Bit 1 shuts down the ADC and bit 0 shuts down the timer. Bits 7:2 ignore writes and always read 0.
- R4: A `sleep_exec` pulse while bit 0 of the mode register is 0 leaves the block awake with all outputs unchanged.
- R5: A `sleep_exec` pulse with sleep armed and a valid mode makes the clock enables {cpu,io,adc,tmr,osc_run} take these values from the next cycle on. Idle gives 0,1,1,1,1. ADC noise reduction gives 0,0,1,0,1. Power-down gives 0,0,0,0,0. Standby gives 0,0,0,0,1. `asleep` goes to 1 at the same time.
- R6: A `sleep_exec` pulse with sleep armed and a reserved mode leaves the block awake and sets `mode_err`. The flag stays set until the next write to the mode register.
- R7: A `wake` pulse while asleep returns the block to awake in the next cycle. All enables come back to 1 except those held off by shutdown bits.
- R8: While the timer shutdown bit is 1, `tmr_clk_en` is 0. Clearing the bit restores `tmr_clk_en` in the next cycle.
- R9: While the ADC shutdown bit is 1, `adc_clk_en` is 0 and `adc_mux_block` is 1.
- R10: A shutdown-register write that would set the ADC bit while `adc_en_in` is 1 leaves the ADC bit at 0 and sets `adc_pr_err`. The timer bit of the same write is still stored. The next shutdown-register write that is not refused clears `adc_pr_err`.
- R11: `wake` while awake has no effect, and `sleep_exec` while asleep has no effect.
- R12: `osc_run` is 0 only in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, reserved bits zero |
| sleep_exec | input | 1 | One-cycle pulse: the core executed a sleep instruction |
| wake | input | 1 | One-cycle wake-up pulse |
| adc_en_in | input | 1 | The ADC is currently enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| osc_run | output | 1 | Keep the oscillator running |
| asleep | output | 1 | The block is in a sleep mode |
| mode_err | output | 1 | Sticky flag: sleep attempted with a reserved mode |
| adc_pr_err | output | 1 | ADC shutdown refused because the ADC was enabled |
| adc_mux_block | output | 1 | The comparator may not use the ADC input multiplexer |

## Verification
A wrong latched mode or a stuck sleep state shows on the clock-enable vector in the cycle after the `sleep_exec` or `wake` edge. The bench samples there, so a wrong mode decode or a missing wake appears within one cycle. A corrupted register shows either on the read port or on the enables it gates, because every stored bit drives an output directly. A mishandled refusal shows at the same edge in the pair of `adc_pr_err` and `adc_mux_block`.

// File: rtl/slp_pkg.sv
package slp_pkg;

    // Mode field encodings; all other values are reserved
    localparam logic [2:0] SM_IDLE  = 3'b000;
    localparam logic [2:0] SM_ADCNR = 3'b001;
    localparam logic [2:0] SM_PDOWN = 3'b010;
    localparam logic [2:0] SM_STBY  = 3'b100;

    // Bit positions inside the mode register
    localparam int MODE_LSB = 1;
    localparam int MODE_W   = 3;
    localparam int ARM_BIT  = 0;

    // Bit positions inside the shutdown register
    localparam int SD_ADC_BIT = 1;
    localparam int SD_TMR_BIT = 0;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic tmr;
        logic osc;
    } clk_en_t;

    function automatic logic mode_reserved(input logic [2:0] m);
        return !((m == SM_IDLE) || (m == SM_ADCNR) ||
                 (m == SM_PDOWN) || (m == SM_STBY));
    endfunction

endpackage

// File: rtl/slp_regs.sv
module slp_regs
    import slp_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int SCR_ADDR = 0,
    parameter int PRR_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              adc_en_in,
    output logic [7:0]        bus_rdata,
    output logic [2:0]        scr_mode,
    output logic              scr_se,
    output logic              scr_wr,
    output logic              prr_adc,
    output logic              prr_tmr,
    output logic              adc_pr_err
);

    localparam logic [ADDR_W-1:0] SCR_A = ADDR_W'(SCR_ADDR);
    localparam logic [ADDR_W-1:0] PRR_A = ADDR_W'(PRR_ADDR);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              se;
        logic              sd_adc;
        logic              sd_tmr;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_scr, hit_prr, refuse;

    always_comb begin
        r_d     = r_q;
        hit_scr = bus_wr && (bus_addr == SCR_A);
        hit_prr = bus_wr && (bus_addr == PRR_A);
        // ADC shutdown is refused while the converter is still enabled
        refuse  = hit_prr && bus_wdata[SD_ADC_BIT] && !r_q.sd_adc && adc_en_in;

        if (hit_scr) begin
            r_d.mode = bus_wdata[MODE_LSB +: MODE_W];
            r_d.se   = bus_wdata[ARM_BIT];
        end

        if (hit_prr) begin
            r_d.sd_tmr = bus_wdata[SD_TMR_BIT];
            r_d.sd_adc = refuse ? r_q.sd_adc : bus_wdata[SD_ADC_BIT];
            r_d.err    = refuse;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux; unused bits are forced to zero
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == SCR_A) begin
            bus_rdata[MODE_LSB +: MODE_W] = r_q.mode;
            bus_rdata[ARM_BIT]            = r_q.se;
        end else if (bus_addr == PRR_A) begin
            bus_rdata[SD_ADC_BIT] = r_q.sd_adc;
            bus_rdata[SD_TMR_BIT] = r_q.sd_tmr;
        end
    end

    assign scr_mode   = r_q.mode;
    assign scr_se     = r_q.se;
    assign scr_wr     = hit_scr;
    assign prr_adc    = r_q.sd_adc;
    assign prr_tmr    = r_q.sd_tmr;
    assign adc_pr_err = r_q.err;

endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_exec,
    input  logic       wake,
    input  logic       scr_se,
    input  logic [2:0] scr_mode,
    input  logic       scr_wr,
    output logic       asleep,
    output logic [2:0] cur_mode,
    output logic       mode_err
);

    typedef struct packed {
        logic       asleep;
        logic [2:0] mode;
        logic       merr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // A mode-register write clears the sticky flag; a new fault in the same cycle wins
        if (scr_wr) begin
            s_d.merr = 1'b0;
        end
        if (!s_q.asleep) begin
            if (sleep_exec && scr_se) begin
                if (mode_reserved(scr_mode)) begin
                    s_d.merr = 1'b1;
                end else begin
                    s_d.asleep = 1'b1;
                    s_d.mode   = scr_mode;
                end
            end
        end else if (wake) begin
            s_d.asleep = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign asleep   = s_q.asleep;
    assign cur_mode = s_q.mode;
    assign mode_err = s_q.merr;

endmodule

// File: rtl/slp_clkgen.sv
module slp_clkgen
    import slp_pkg::*;
#(
    parameter bit TMR_RUN_IN_ADCNR = 1'b0
) (
    input  logic       asleep,
    input  logic [2:0] cur_mode,
    input  logic       prr_adc,
    input  logic       prr_tmr,
    output clk_en_t    ce
);

    logic tmr_nr;

    // Variant: whether the timer keeps ticking in ADC noise reduction
    generate
        if (TMR_RUN_IN_ADCNR) begin : g_tmr_nr_on
            assign tmr_nr = 1'b1;
        end else begin : g_tmr_nr_off
            assign tmr_nr = 1'b0;
        end
    endgenerate

    clk_en_t base;

    always_comb begin
        base = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, tmr: 1'b1, osc: 1'b1};
        if (asleep) begin
            case (cur_mode)
                SM_IDLE:  base = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, tmr: 1'b1, osc: 1'b1};
                SM_ADCNR: base = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, tmr: tmr_nr, osc: 1'b1};
                SM_PDOWN: base = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b0, osc: 1'b0};
                SM_STBY:  base = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b0, osc: 1'b1};
                default:  base = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b0, osc: 1'b0};
            endcase
        end
        ce     = base;
        ce.adc = base.adc && !prr_adc;
        ce.tmr = base.tmr && !prr_tmr;
    end

endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
    import slp_pkg::*;
#(
    parameter int ADDR_W           = 2,
    parameter int SCR_ADDR         = 0,
    parameter int PRR_ADDR         = 1,
    parameter bit TMR_RUN_IN_ADCNR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sleep_exec,
    input  logic              wake,
    input  logic              adc_en_in,
    output logic              cpu_clk_en,
    output logic              io_clk_en,
    output logic              adc_clk_en,
    output logic              tmr_clk_en,
    output logic              osc_run,
    output logic              asleep,
    output logic              mode_err,
    output logic              adc_pr_err,
    output logic              adc_mux_block
);

    logic [2:0] scr_mode;
    logic       scr_se;
    logic       scr_wr;
    logic       prr_adc;
    logic       prr_tmr;
    logic [2:0] cur_mode;
    clk_en_t    ce;

    slp_regs #(
        .ADDR_W  (ADDR_W),
        .SCR_ADDR(SCR_ADDR),
        .PRR_ADDR(PRR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .adc_en_in (adc_en_in),
        .bus_rdata (bus_rdata),
        .scr_mode  (scr_mode),
        .scr_se    (scr_se),
        .scr_wr    (scr_wr),
        .prr_adc   (prr_adc),
        .prr_tmr   (prr_tmr),
        .adc_pr_err(adc_pr_err)
    );

    slp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_exec(sleep_exec),
        .wake      (wake),
        .scr_se    (scr_se),
        .scr_mode  (scr_mode),
        .scr_wr    (scr_wr),
        .asleep    (asleep),
        .cur_mode  (cur_mode),
        .mode_err  (mode_err)
    );

    slp_clkgen #(
        .TMR_RUN_IN_ADCNR(TMR_RUN_IN_ADCNR)
    ) u_clkgen (
        .asleep  (asleep),
        .cur_mode(cur_mode),
        .prr_adc (prr_adc),
        .prr_tmr (prr_tmr),
        .ce      (ce)
    );

    assign cpu_clk_en    = ce.cpu;
    assign io_clk_en     = ce.io;
    assign adc_clk_en    = ce.adc;
    assign tmr_clk_en    = ce.tmr;
    assign osc_run       = ce.osc;
    assign adc_mux_block = prr_adc;

endmodule

// File: rtl/slp_pwr_ctrl_chk.sv
module slp_pwr_ctrl_chk
    import slp_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int PRR_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              sleep_exec,
    input logic              wake,
    input logic              adc_en_in,
    input logic              cpu_clk_en,
    input logic              io_clk_en,
    input logic              adc_clk_en,
    input logic              osc_run,
    input logic              asleep,
    input logic              mode_err,
    input logic              adc_pr_err,
    input logic              adc_mux_block,
    input logic              scr_se,
    input logic [2:0]        scr_mode
);

    localparam logic [ADDR_W-1:0] PRR_A = ADDR_W'(PRR_ADDR);

    assert_hi_nibble_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:4] == 4'h0);

    assert_sd_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PRR_A) |-> (bus_rdata[7:2] == 6'h00));

    assert_unarmed_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && sleep_exec && !scr_se) |=> !asleep);

    assert_cpu_off_in_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !cpu_clk_en);

    assert_awake_core_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |-> (cpu_clk_en && io_clk_en && osc_run));

    assert_rsvd_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && sleep_exec && scr_se && mode_reserved(scr_mode)) |=> (!asleep && mode_err));

    assert_wake_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake) |=> !asleep);

    assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !wake) |=> asleep);

    assert_mux_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_mux_block |-> !adc_clk_en);

    assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PRR_A && bus_wdata[1] && adc_en_in && !adc_mux_block)
        |=> (adc_pr_err && !adc_mux_block));

    assert_osc_only_pdown_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> asleep);

endmodule

bind slp_pwr_ctrl slp_pwr_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .PRR_ADDR(PRR_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .sleep_exec   (sleep_exec),
    .wake         (wake),
    .adc_en_in    (adc_en_in),
    .cpu_clk_en   (cpu_clk_en),
    .io_clk_en    (io_clk_en),
    .adc_clk_en   (adc_clk_en),
    .osc_run      (osc_run),
    .asleep       (asleep),
    .mode_err     (mode_err),
    .adc_pr_err   (adc_pr_err),
    .adc_mux_block(adc_mux_block),
    .scr_se       (scr_se),
    .scr_mode     (scr_mode)
);

// File: tb/slp_pwr_ctrl_test.sv
module slp_pwr_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sleep_exec = 1'b0;
    logic       wake = 1'b0;
    logic       adc_en_in = 1'b0;
    logic       cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, osc_run;
    logic       asleep, mode_err, adc_pr_err, adc_mux_block;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // kinds: 0 read data, 1 {cpu,io,adc,tmr,osc}, 2 {asleep,mode_err,adc_pr_err,adc_mux_block}
    typedef struct {
        int         kind;
        logic [7:0] exp;
        int         due;
        string      tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    slp_pwr_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .sleep_exec   (sleep_exec),
        .wake         (wake),
        .adc_en_in    (adc_en_in),
        .cpu_clk_en   (cpu_clk_en),
        .io_clk_en    (io_clk_en),
        .adc_clk_en   (adc_clk_en),
        .tmr_clk_en   (tmr_clk_en),
        .osc_run      (osc_run),
        .asleep       (asleep),
        .mode_err     (mode_err),
        .adc_pr_err   (adc_pr_err),
        .adc_mux_block(adc_mux_block)
    );

    function automatic logic [7:0] observe(input int kind);
        case (kind)
            0:       return bus_rdata;
            1:       return {3'b000, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, osc_run};
            default: return {4'h0, asleep, mode_err, adc_pr_err, adc_mux_block};
        endcase
    endfunction

    // Monitor: samples 3 ns after each rising edge, before inputs move
    always @(posedge clk) begin
        #3;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = observe(it.kind);
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, got, it.exp);
            end
        end
    end

    task automatic drv(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic s, input logic k, input logic e);
        @(negedge clk);
        bus_wr     = w;
        bus_addr   = a;
        bus_wdata  = d;
        sleep_exec = s;
        wake       = k;
        adc_en_in  = e;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] v, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = v;
        it.due  = cyc + 1;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        drv(0, 2'd0, 8'h00, 0, 0, 0);
        expect_item(0, 8'h00, "R1 mode reg");
        expect_item(1, 8'h1F, "R1 enables");
        expect_item(2, 8'h00, "R1 flags");
        drv(0, 2'd1, 8'h00, 0, 0, 0);
        expect_item(0, 8'h00, "R1 shutdown reg");

        // R2 field layout and zero high nibble
        drv(1, 2'd0, 8'hFF, 0, 0, 0);
        drv(0, 2'd0, 8'h00, 0, 0, 0);
        expect_item(0, 8'h0F, "R2 readback");

        // R6 reserved mode 111 with sleep armed
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(2, 8'h04, "R6 flag set");
        expect_item(1, 8'h1F, "R6 stays awake");
        drv(0, 2'd0, 8'h00, 0, 0, 0);
        expect_item(2, 8'h04, "R6 sticky");
        drv(1, 2'd0, 8'h01, 0, 0, 0);
        expect_item(2, 8'h00, "R6 cleared by write");

        // R5 idle
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h0F, "R5 idle enables");
        expect_item(2, 8'h08, "R5 asleep");
        // R11 sleep while asleep
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h0F, "R11 sleep ignored");
        expect_item(2, 8'h08, "R11 still asleep");
        // R7 wake
        drv(0, 2'd0, 8'h00, 0, 1, 0);
        expect_item(1, 8'h1F, "R7 wake enables");
        expect_item(2, 8'h00, "R7 awake");
        // R11 wake while awake
        drv(0, 2'd0, 8'h00, 0, 1, 0);
        expect_item(1, 8'h1F, "R11 wake ignored");
        expect_item(2, 8'h00, "R11 flags");

        // R4 not armed
        drv(1, 2'd0, 8'h04, 0, 0, 0);
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h1F, "R4 no entry");
        expect_item(2, 8'h00, "R4 awake");

        // R5 R12 power-down
        drv(1, 2'd0, 8'h05, 0, 0, 0);
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h00, "R5 R12 power-down");
        drv(0, 2'd0, 8'h00, 0, 1, 0);
        expect_item(1, 8'h1F, "R7 wake from power-down");

        // R5 ADC noise reduction
        drv(1, 2'd0, 8'h03, 0, 0, 0);
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h05, "R5 noise reduction");
        drv(0, 2'd0, 8'h00, 0, 1, 0);
        expect_item(1, 8'h1F, "R7 wake from noise reduction");

        // R5 R12 standby
        drv(1, 2'd0, 8'h09, 0, 0, 0);
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h01, "R5 R12 standby");
        drv(0, 2'd0, 8'h00, 0, 1, 0);
        expect_item(1, 8'h1F, "R7 wake from standby");

        // R3 R8 R9 shutdown register
        drv(1, 2'd1, 8'hFF, 0, 0, 0);
        expect_item(1, 8'h19, "R8 R9 both gated");
        expect_item(2, 8'h01, "R9 mux blocked");
        drv(0, 2'd1, 8'h00, 0, 0, 0);
        expect_item(0, 8'h03, "R3 readback");
        drv(1, 2'd1, 8'h02, 0, 0, 0);
        expect_item(1, 8'h1B, "R8 timer resumes");
        expect_item(2, 8'h01, "R9 still blocked");

        // R7 wake keeps shutdown gating
        drv(1, 2'd0, 8'h01, 0, 0, 0);
        drv(0, 2'd0, 8'h00, 1, 0, 0);
        expect_item(1, 8'h0B, "R5 idle with adc off");
        expect_item(2, 8'h09, "R5 asleep blocked");
        drv(0, 2'd0, 8'h00, 0, 1, 0);
        expect_item(1, 8'h1B, "R7 adc stays off");
        expect_item(2, 8'h01, "R7 awake blocked");
        drv(1, 2'd1, 8'h00, 0, 0, 0);
        expect_item(1, 8'h1F, "R9 adc back on");
        expect_item(2, 8'h00, "R9 unblocked");

        // R10 refusal
        drv(1, 2'd1, 8'h03, 0, 0, 1);
        expect_item(1, 8'h1D, "R10 timer applied adc not");
        expect_item(2, 8'h02, "R10 error set");
        drv(0, 2'd1, 8'h00, 0, 0, 1);
        expect_item(0, 8'h01, "R10 readback");
        drv(1, 2'd1, 8'h00, 0, 0, 1);
        expect_item(2, 8'h00, "R10 error cleared");
        expect_item(1, 8'h1F, "R10 enables");
        drv(1, 2'd1, 8'h02, 0, 0, 0);
        expect_item(2, 8'h01, "R9 accepted when adc disabled");
        expect_item(1, 8'h1B, "R9 adc gated");

        drv(0, 2'd0, 8'h00, 0, 0, 0);
        repeat (3) @(posedge clk);
        #5;
        if (sb.size() != 0) begin
            bad++;
            total++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule